// File: doc/BRIEF.md
# Looped Shift and Storage Register

The block pairs a serial shift register with a storage register of the same width, default 16 bits. The two registers form a closed parallel loop. The storage register can capture a snapshot of the shift register, and its parallel outputs then show the shift-register status. The shift register can also be reloaded from the storage register.

A single three-state serial pin does two jobs. In write mode it carries serial data into bit 0. In read mode it drives the last stage, bit 15, and that bit also wraps back into bit 0, so a full read leaves the word unchanged. The pin is modelled as three signals: a data input, a data output and an output enable.

An active-low chip select gates both register clocks and the pin driver. A separate active-low clear empties the storage register at once, without waiting for a clock edge.

Top module: `loop_shift_store`

## Requirements
- R1: While reset is low, both registers are zero and `sio_oe` is 0. After reset, a store shows 0 on `par_out`.
- R2: With `cs_n`=0, `rw`=0 and `shift_nload`=1, each rising edge moves bit i to bit i+1 and loads `sio_in` into bit 0. `sio_out` always equals bit 15 of the shift register.
- R3: With `cs_n`=0, `rw`=1 and `shift_nload`=1, `sio_oe` is 1 and each edge rotates the word, so bit 15 re-enters at bit 0. After 16 edges the word is unchanged, and its bits appear on `sio_out` with bit 15 first.
- R4: With `cs_n`=0 and `shift_nload`=0, a rising edge copies the storage register into the shift register.
- R5: With `cs_n`=0 and `store_en`=1, a rising edge copies the shift-register value from before that edge into the storage register, and `par_out` shows it.
- R6: A store and a load on the same edge exchange the two registers.
- R7: `clr_n`=0 zeroes the storage register immediately, with no clock edge, and it stays zero across edges that request a store.
- R8: With `cs_n`=1, `sio_oe` is 0 and clock edges change neither register, whatever the other controls are.
- R9: With `store_en`=0, the storage register holds its value across enabled edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; gates both clocks and the pin driver |
| rw | input | 1 | 1 = read (pin driven, word recirculates), 0 = write (pin is input) |
| shift_nload | input | 1 | 1 = shift one place, 0 = parallel load from storage |
| store_en | input | 1 | Storage register captures the shift register on an enabled edge |
| clr_n | input | 1 | Asynchronous active-low clear of the storage register |
| sio_in | input | 1 | Serial pin value seen as input |
| sio_out | output | 1 | Serial pin drive value (shift-register bit 15) |
| sio_oe | output | 1 | Serial pin output enable |
| par_out | output | WIDTH | Parallel outputs of the storage register |

## Verification
The bench builds the block with its default WIDTH of 16, so every word uses the full width. At that width each run of sixteen write or rotate edges is short enough to check bit by bit. The known patterns are chosen so that each tested exchange, load and shift gives a value that differs from the one before it. Together these make it possible to see a register that was wrongly gated, cleared or loaded.

// File: rtl/lss_pkg.sv
package lss_pkg;
    typedef enum logic [1:0] {
        SR_HOLD   = 2'd0,
        SR_SHIFT  = 2'd1,
        SR_RECIRC = 2'd2,
        SR_LOAD   = 2'd3
    } sr_op_e;
endpackage

// File: rtl/lss_ctrl.sv
module lss_ctrl
    import lss_pkg::*;
(
    input  logic   rst_n,
    input  logic   cs_n,
    input  logic   rw,
    input  logic   shift_nload,
    input  logic   store_en,
    output sr_op_e sr_op,
    output logic   store_stb,
    output logic   pin_oe
);
    always_comb begin
        if (cs_n)
            sr_op = SR_HOLD;
        else if (!shift_nload)
            sr_op = SR_LOAD;
        else if (rw)
            sr_op = SR_RECIRC;
        else
            sr_op = SR_SHIFT;
        store_stb = !cs_n && store_en;
        pin_oe    = rst_n && !cs_n && rw;
    end
endmodule

// File: rtl/lss_shift.sv
module lss_shift
    import lss_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  sr_op_e       op,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] bits;
    } shift_state_t;

    shift_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (op)
            SR_SHIFT:  s_d.bits = {s_q.bits[W-2:0], ser_in};
            SR_RECIRC: s_d.bits = {s_q.bits[W-2:0], s_q.bits[W-1]};
            SR_LOAD:   s_d.bits = par_in;
            default:   s_d.bits = s_q.bits;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign q = s_q.bits;
endmodule

// File: rtl/lss_store.sv
module lss_store #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         stb,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] word;
    } store_state_t;

    store_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (stb)
            s_d.word = d;
    end

    always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
        if (!rst_n)
            s_q <= '0;
        else if (!clr_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign q = s_q.word;
endmodule

// File: rtl/loop_shift_store.sv
module loop_shift_store
    import lss_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rw,
    input  logic             shift_nload,
    input  logic             store_en,
    input  logic             clr_n,
    input  logic             sio_in,
    output logic             sio_out,
    output logic             sio_oe,
    output logic [WIDTH-1:0] par_out
);
    localparam int MSB = WIDTH - 1;

    sr_op_e           sr_op;
    logic             store_stb;
    logic [WIDTH-1:0] sr_q;
    logic [WIDTH-1:0] st_q;

    lss_ctrl u_ctrl (
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .rw          (rw),
        .shift_nload (shift_nload),
        .store_en    (store_en),
        .sr_op       (sr_op),
        .store_stb   (store_stb),
        .pin_oe      (sio_oe)
    );

    lss_shift #(.W(WIDTH)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (sr_op),
        .ser_in (sio_in),
        .par_in (st_q),
        .q      (sr_q)
    );

    lss_store #(.W(WIDTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_n),
        .stb   (store_stb),
        .d     (sr_q),
        .q     (st_q)
    );

    assign sio_out = sr_q[MSB];
    assign par_out = st_q;
endmodule

// File: rtl/lss_checker.sv
module lss_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cs_n,
    input logic         rw,
    input logic         shift_nload,
    input logic         store_en,
    input logic         clr_n,
    input logic         sio_in,
    input logic         sio_oe,
    input logic [W-1:0] sr_q,
    input logic [W-1:0] st_q
);
    // R2
    shift_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && shift_nload && !rw) |=> (sr_q == {$past(sr_q[W-2:0]), $past(sio_in)}));

    // R3
    shift_recirc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && shift_nload && rw) |=> (sr_q == {$past(sr_q[W-2:0]), $past(sr_q[W-1])}));

    // R4
    load_from_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !shift_nload) |=> (sr_q == $past(st_q)));

    // R5
    store_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && store_en && clr_n) |=> (!clr_n || st_q == $past(sr_q)));

    // R7
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (st_q == '0));

    // R8
    cs_pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sio_oe);

    // R8
    cs_shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(sr_q));

    // R9
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cs_n || !store_en) && clr_n) |=> (!clr_n || $stable(st_q)));
endmodule

bind loop_shift_store lss_checker #(.W(WIDTH)) u_lss_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .rw          (rw),
    .shift_nload (shift_nload),
    .store_en    (store_en),
    .clr_n       (clr_n),
    .sio_in      (sio_in),
    .sio_oe      (sio_oe),
    .sr_q        (sr_q),
    .st_q        (st_q)
);

// File: tb/loop_shift_store_test.sv
module loop_shift_store_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b0;
    logic         rw = 1'b1;
    logic         shift_nload = 1'b1;
    logic         store_en = 1'b0;
    logic         clr_n = 1'b1;
    logic         sio_in = 1'b0;
    logic         sio_out;
    logic         sio_oe;
    logic [W-1:0] par_out;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    loop_shift_store #(.WIDTH(W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .rw          (rw),
        .shift_nload (shift_nload),
        .store_en    (store_en),
        .clr_n       (clr_n),
        .sio_in      (sio_in),
        .sio_out     (sio_out),
        .sio_oe      (sio_oe),
        .par_out     (par_out)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_ctl(input logic c, input logic r, input logic s, input logic st);
        cs_n = c; rw = r; shift_nload = s; store_en = st;
    endtask

    task automatic write_word(input logic [W-1:0] v);
        set_ctl(1'b0, 1'b0, 1'b1, 1'b0);
        for (int i = W - 1; i >= 0; i--) begin
            sio_in = v[i];
            tick();
        end
        sio_in = 1'b0;
    endtask

    task automatic t_reset();
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        tick();
        chk("R1 par_out in reset", par_out, '0);
        chk("R1 oe in reset", {15'd0, sio_oe}, 16'd0);
        rst_n = 1'b1;
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
        tick();
        chk("R1 store after reset", par_out, '0);
    endtask

    task automatic t_write();
        write_word(16'hA5C3);
        chk("R9 storage held during write", par_out, '0);
        chk("R2 sio_out bit15", {15'd0, sio_out}, 16'd1);
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
        tick();
        chk("R5 store after write", par_out, 16'hA5C3);
        chk("R2 sio_out after shift", {15'd0, sio_out}, 16'd0);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
        tick();
        chk("R4 sio_out after load", {15'd0, sio_out}, 16'd1);
    endtask

    task automatic t_swap();
        write_word(16'h3C96);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        tick();
        chk("R6 storage after exchange", par_out, 16'h3C96);
    endtask

    task automatic t_read();
        logic [W-1:0] got;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        #1;
        chk("R3 oe in read mode", {15'd0, sio_oe}, 16'd1);
        for (int i = W - 1; i >= 0; i--) begin
            got[i] = sio_out;
            tick();
        end
        chk("R3 serial read bits", got, 16'hA5C3);
        set_ctl(1'b0, 1'b1, 1'b0, 1'b1);
        tick();
        chk("R3 word intact after rotate", par_out, 16'hA5C3);
    endtask

    task automatic t_cs();
        write_word(16'h1234);
        set_ctl(1'b1, 1'b1, 1'b0, 1'b1);
        #1;
        chk("R8 oe off with cs high", {15'd0, sio_oe}, 16'd0);
        for (int i = 0; i < 3; i++) begin
            sio_in = ~sio_in;
            tick();
        end
        chk("R8 storage held with cs high", par_out, 16'hA5C3);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        tick();
        chk("R8 shift reg held with cs high", par_out, 16'h1234);
    endtask

    task automatic t_clear();
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
        sio_in = 1'b0;
        clr_n = 1'b0;
        #1;
        chk("R7 clear without edge", par_out, '0);
        @(negedge clk);
        chk("R7 clear beats store", par_out, '0);
        clr_n = 1'b1;
        store_en = 1'b0;
        tick();
        chk("R9 storage stays cleared", par_out, '0);
        store_en = 1'b1;
        tick();
        chk("R5 store after clear", par_out, 16'h970C);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_write();
        t_swap();
        t_read();
        t_cs();
        t_clear();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule